// File: doc/BRIEF.md
# Window Comparator with Consecutive-Event Filter

This block watches a stream of 12-bit conversion codes, each marked by a one-cycle valid strobe. It compares each code against a programmable low bound and high bound. Both comparisons are inclusive. When the code is at or below the low bound, the low comparator flag sets. When the code is at or above the high bound, the high comparator flag sets. Once a flag is set, it releases only after the code has moved back inside the window by more than a programmable hysteresis margin. The release points saturate at the code limits.

A filter stands between the flags and the alert output. The alert rises only after a run of consecutive out-of-window conversions. The run must be one longer than a programmed 4-bit count, so a count of zero fires on the first such conversion. Any conversion that leaves both flags clear breaks the run. The filter is a four-state machine:
- OFF: disabled.
- WATCH: in the window, with no run in progress.
- COUNT: a run is in progress.
- ALERT: the alert is driven.

The transitions are:
- enable low sends any state to OFF.
- OFF moves to WATCH once enable is high.
- WATCH (or OFF with enable high) on an out-of-window conversion goes to ALERT when the count is zero, and to COUNT otherwise.
- COUNT on an out-of-window conversion goes to ALERT once the run has reached the count. Otherwise it lengthens the run.
- COUNT or ALERT on an in-window conversion returns to WATCH.

Two sticky flags record which side drove the alert. They hold until the host pulses the clear input.

By moving the bounds to the code limits, the same block serves as a low-only, high-only or two-sided window detector.

Top module: `wincmp_evt`

## Requirements
- R1: The low flag `cmp_lo` sets on a valid conversion whose code is less than or equal to `thr_lo`.
- R2: The high flag `cmp_hi` sets on a valid conversion whose code is greater than or equal to `thr_hi`.
- R3: With `thr_hi` = 0xFFF, only a code of exactly 0xFFF sets the high flag. With `thr_lo` = 0x000, only a code of exactly 0x000 sets the low flag.
- R4: A set low flag stays set until a valid code exceeds `thr_lo + hyst`. That sum saturates at 0xFFF, so a saturated bound never releases the flag.
- R5: A set high flag stays set until a valid code falls below `thr_hi - hyst`. That difference saturates at 0x000, so a saturated bound never releases the flag.
- R6: `alert` rises on the valid conversion that makes the run of consecutive out-of-window conversions (either flag set after the update) equal to `evt_need + 1`. With `evt_need` = 0, it rises on the first such conversion.
- R7: A valid conversion that leaves both flags clear ends the run and drops `alert`. After that, the count starts again from zero.
- R8: Whenever a valid conversion drives or keeps `alert` high, `stk_lo` and `stk_hi` latch the low and high flags of that conversion. They hold until `flag_clr` is high at a clock edge. When setting and clearing fall in the same cycle, setting wins.
- R9: Cycles without `smp_valid` change neither flags nor alert. While `en` is low, the flags, alert and run are all cleared, and the sticky flags keep their values.
- R10: Flags and alert take their new value at the clock edge that samples the valid strobe. They remain unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears flags, alert and run |
| smp_valid | input | 1 | One-cycle strobe marking a new conversion |
| smp_code | input | 12 | Conversion code |
| thr_lo | input | 12 | Low bound (inclusive) |
| thr_hi | input | 12 | High bound (inclusive) |
| hyst | input | 12 | Release margin for both flags |
| evt_need | input | 4 | Extra consecutive conversions required before alert |
| flag_clr | input | 1 | Clears the sticky flags |
| cmp_lo | output | 1 | Low comparator flag |
| cmp_hi | output | 1 | High comparator flag |
| alert | output | 1 | Filtered alert level |
| stk_lo | output | 1 | Sticky: low side caused an alert |
| stk_hi | output | 1 | Sticky: high side caused an alert |

## Verification
Each comparison is tested with codes one step on either side of its bound. This separates inclusive from strict compares. The same tests are repeated with the bounds at 0x000 and 0xFFF. Hysteresis runs step the code to exactly the release point and one past it, and also use settings that saturate the release bound. These separate a correct release from an off-by-one error and from a wrapped sum or difference. The filter receives runs one short of the count, exactly long enough, and broken midway by an in-window code. The runs are also interleaved with idle cycles and with an enable drop, which shows whether the counter advances only on strobes and restarts after a break.

// File: rtl/wincmp_pkg.sv
package wincmp_pkg;

    // States of the consecutive-event filter
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_COUNT = 2'd2,
        ST_ALERT = 2'd3
    } flt_state_t;

endpackage

// File: rtl/wincmp_side.sv
module wincmp_side #(
    parameter int DATA_W  = 12,
    parameter bit IS_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              valid,
    input  logic [DATA_W-1:0] code,
    input  logic [DATA_W-1:0] thr,
    input  logic [DATA_W-1:0] hys,
    output logic              flag_q,
    output logic              flag_d
);
    logic [DATA_W-1:0] rel_bound;
    logic              hit;
    logic              release_now;

    generate
        if (IS_HIGH) begin : g_high
            logic [DATA_W:0] diff;
            assign diff        = {1'b0, thr} - {1'b0, hys};
            assign rel_bound   = diff[DATA_W] ? '0 : diff[DATA_W-1:0];
            assign hit         = (code >= thr);
            assign release_now = (code < rel_bound);
        end else begin : g_low
            logic [DATA_W:0] sum;
            assign sum         = {1'b0, thr} + {1'b0, hys};
            assign rel_bound   = sum[DATA_W] ? '1 : sum[DATA_W-1:0];
            assign hit         = (code <= thr);
            assign release_now = (code > rel_bound);
        end
    endgenerate

    always_comb begin
        if (!en) begin
            flag_d = 1'b0;
        end else if (valid) begin
            flag_d = flag_q ? !release_now : hit;
        end else begin
            flag_d = flag_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

endmodule

// File: rtl/wincmp_filter.sv
module wincmp_filter
    import wincmp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             valid,
    input  logic             outside,
    input  logic [CNT_W-1:0] need,
    output logic             alert,
    output logic             fire
);
    flt_state_t       st_q, st_d;
    logic [CNT_W-1:0] run_q, run_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        fire  = 1'b0;
        if (!en) begin
            st_d  = ST_OFF;
            run_d = '0;
        end else begin
            unique case (st_q)
                ST_OFF, ST_WATCH: begin
                    st_d  = ST_WATCH;
                    run_d = '0;
                    if (valid && outside) begin
                        if (need == '0) begin
                            st_d = ST_ALERT;
                            fire = 1'b1;
                        end else begin
                            st_d  = ST_COUNT;
                            run_d = CNT_W'(1);
                        end
                    end
                end
                ST_COUNT: begin
                    if (valid) begin
                        if (!outside) begin
                            st_d  = ST_WATCH;
                            run_d = '0;
                        end else if (run_q >= need) begin
                            st_d  = ST_ALERT;
                            run_d = '0;
                            fire  = 1'b1;
                        end else begin
                            run_d = run_q + CNT_W'(1);
                        end
                    end
                end
                ST_ALERT: begin
                    if (valid) begin
                        if (outside) begin
                            fire = 1'b1;
                        end else begin
                            st_d = ST_WATCH;
                        end
                    end
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        alert = (st_q == ST_ALERT);
    end

endmodule

// File: rtl/wincmp_sticky.sv
module wincmp_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic lo_d,
    input  logic hi_d,
    input  logic clr,
    output logic stk_lo,
    output logic stk_hi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_lo <= 1'b0;
            stk_hi <= 1'b0;
        end else begin
            if (fire && lo_d) stk_lo <= 1'b1;
            else if (clr)     stk_lo <= 1'b0;
            if (fire && hi_d) stk_hi <= 1'b1;
            else if (clr)     stk_hi <= 1'b0;
        end
    end
endmodule

// File: rtl/wincmp_evt.sv
module wincmp_evt #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_code,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] hyst,
    input  logic [CNT_W-1:0]  evt_need,
    input  logic              flag_clr,
    output logic              cmp_lo,
    output logic              cmp_hi,
    output logic              alert,
    output logic              stk_lo,
    output logic              stk_hi
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0]        flg_q, flg_d;
    logic [DATA_W-1:0]       side_thr [NSIDE];
    logic                    fire;

    assign side_thr[0] = thr_lo;
    assign side_thr[1] = thr_hi;

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            wincmp_side #(.DATA_W(DATA_W), .IS_HIGH(s == 1)) u_side (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (en),
                .valid  (smp_valid),
                .code   (smp_code),
                .thr    (side_thr[s]),
                .hys    (hyst),
                .flag_q (flg_q[s]),
                .flag_d (flg_d[s])
            );
        end
    endgenerate

    wincmp_filter #(.CNT_W(CNT_W)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .valid   (smp_valid),
        .outside (|flg_d),
        .need    (evt_need),
        .alert   (alert),
        .fire    (fire)
    );

    wincmp_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .lo_d   (flg_d[0]),
        .hi_d   (flg_d[1]),
        .clr    (flag_clr),
        .stk_lo (stk_lo),
        .stk_hi (stk_hi)
    );

    assign cmp_lo = flg_q[0];
    assign cmp_hi = flg_q[1];

endmodule

// File: rtl/wincmp_chk.sv
module wincmp_chk #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_code,
    input logic [DATA_W-1:0] thr_lo,
    input logic [DATA_W-1:0] thr_hi,
    input logic [CNT_W-1:0]  evt_need,
    input logic              flag_clr,
    input logic              cmp_lo,
    input logic              cmp_hi,
    input logic              alert,
    input logic              stk_lo,
    input logic              stk_hi
);
    assert_lo_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_lo) |-> $past(en && smp_valid && (smp_code <= thr_lo)));

    assert_hi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_hi) |-> $past(en && smp_valid && (smp_code >= thr_hi)));

    assert_lo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && smp_valid && (smp_code <= thr_lo)) |=> cmp_lo);

    assert_hi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && smp_valid && (smp_code >= thr_hi)) |=> cmp_hi);

    assert_alert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert) |-> $past(en && smp_valid));

    assert_alert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alert |-> (cmp_lo || cmp_hi));

    assert_stk_lo_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stk_lo) |-> $past(flag_clr));

    assert_stk_hi_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stk_hi) |-> $past(flag_clr));

    assert_stk_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stk_lo) || $rose(stk_hi)) |-> alert);

    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!alert && !cmp_lo && !cmp_hi));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !smp_valid) |=> ($stable(alert) && $stable(cmp_lo) && $stable(cmp_hi)));

endmodule

bind wincmp_evt wincmp_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .smp_valid (smp_valid),
    .smp_code  (smp_code),
    .thr_lo    (thr_lo),
    .thr_hi    (thr_hi),
    .evt_need  (evt_need),
    .flag_clr  (flag_clr),
    .cmp_lo    (cmp_lo),
    .cmp_hi    (cmp_hi),
    .alert     (alert),
    .stk_lo    (stk_lo),
    .stk_hi    (stk_hi)
);

// File: tb/sim_wincmp_evt.sv
module sim_wincmp_evt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_code = '0;
    logic [11:0] thr_lo = '0;
    logic [11:0] thr_hi = 12'hFFF;
    logic [11:0] hyst = '0;
    logic [3:0]  evt_need = '0;
    logic        flag_clr = 1'b0;
    logic        cmp_lo, cmp_hi, alert, stk_lo, stk_hi;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wincmp_evt u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
        .smp_code(smp_code), .thr_lo(thr_lo), .thr_hi(thr_hi), .hyst(hyst),
        .evt_need(evt_need), .flag_clr(flag_clr), .cmp_lo(cmp_lo),
        .cmp_hi(cmp_hi), .alert(alert), .stk_lo(stk_lo), .stk_hi(stk_hi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Program bounds, pulse enable low and clear the sticky flags
    task automatic cfg(input int lo, input int hi, input int hy, input int need);
        @(negedge clk);
        en = 1'b0; flag_clr = 1'b1;
        thr_lo = 12'(lo); thr_hi = 12'(hi); hyst = 12'(hy); evt_need = 4'(need);
        @(negedge clk);
        en = 1'b1; flag_clr = 1'b0;
    endtask

    task automatic send(input int code);
        @(negedge clk);
        smp_code = 12'(code); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 reset alert", alert, 0);
        chk("R9 reset cmp_lo", cmp_lo, 0);
        chk("R9 reset cmp_hi", cmp_hi, 0);
        chk("R8 reset stk_lo", stk_lo, 0);
        chk("R8 reset stk_hi", stk_hi, 0);
    endtask

    task automatic t_low();
        cfg(100, 12'hFFF, 0, 0);
        send(101); chk("R1 code above low bound", cmp_lo, 0);
        // R10: value unchanged before the sampling edge
        @(negedge clk);
        smp_code = 12'd100; smp_valid = 1'b1;
        #(CLK_PERIOD/2 - 1);
        chk("R10 before edge cmp_lo", cmp_lo, 0);
        chk("R10 before edge alert", alert, 0);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R1 code equal low bound", cmp_lo, 1);
        chk("R10 after edge alert", alert, 1);
        send(101);
        chk("R4 release with zero margin", cmp_lo, 0);
        chk("R7 alert drops in window", alert, 0);
    endtask

    task automatic t_high();
        cfg(0, 200, 0, 0);
        send(199); chk("R2 code below high bound", cmp_hi, 0);
        send(200); chk("R2 code equal high bound", cmp_hi, 1);
        chk("R2 alert on high", alert, 1);
    endtask

    task automatic t_extremes();
        cfg(0, 12'hFFF, 0, 0);
        send(12'hFFE); chk("R3 0xFFE no high", cmp_hi, 0);
        chk("R3 0xFFE no low", cmp_lo, 0);
        send(12'hFFF); chk("R3 full scale high", cmp_hi, 1);
        send(1); chk("R3 code 1 releases high", cmp_hi, 0);
        chk("R3 code 1 no low", cmp_lo, 0);
        send(0); chk("R3 zero sets low", cmp_lo, 1);
    endtask

    task automatic t_hys_low();
        cfg(100, 12'hFFF, 20, 0);
        send(90);  chk("R4 set", cmp_lo, 1);
        send(120); chk("R4 hold at bound+hys", cmp_lo, 1);
        send(121); chk("R4 release beyond", cmp_lo, 0);
        cfg(12'hFF0, 12'hFFF, 12'h100, 0);
        send(12'hFF0); chk("R4 sat set", cmp_lo, 1);
        send(12'hFFE); chk("R4 saturated bound holds", cmp_lo, 1);
    endtask

    task automatic t_hys_high();
        cfg(0, 300, 50, 0);
        send(310); chk("R5 set", cmp_hi, 1);
        send(250); chk("R5 hold at bound-hys", cmp_hi, 1);
        send(249); chk("R5 release below", cmp_hi, 0);
        cfg(0, 10, 50, 0);
        send(10); chk("R5 sat set", cmp_hi, 1);
        send(1);  chk("R5 saturated bound holds", cmp_hi, 1);
    endtask

    task automatic t_count();
        cfg(100, 12'hFFF, 0, 3);
        for (int i = 0; i < 3; i++) begin
            send(50); chk("R6 run short of count", alert, 0);
        end
        send(50); chk("R6 run reaches count+1", alert, 1);
    endtask

    task automatic t_break();
        cfg(100, 12'hFFF, 0, 2);
        send(50); send(50);
        send(150); chk("R7 in-window breaks run", alert, 0);
        send(50); send(50); chk("R7 run restarted", alert, 0);
        send(50); chk("R7 fresh run fires", alert, 1);
        send(150); chk("R7 alert drops", alert, 0);
    endtask

    task automatic t_sticky();
        cfg(100, 200, 0, 0);
        send(250);
        chk("R8 high sticky", stk_hi, 1);
        chk("R8 low sticky untouched", stk_lo, 0);
        send(150);
        chk("R8 sticky holds after alert drops", stk_hi, 1);
        // alerting conversion together with clear: set wins for low side
        @(negedge clk);
        smp_code = 12'd50; smp_valid = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; flag_clr = 1'b0;
        chk("R8 set wins over clear", stk_lo, 1);
        chk("R8 clear drops other side", stk_hi, 0);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R8 clear pulse", stk_lo, 0);
    endtask

    task automatic t_valid_en();
        cfg(100, 12'hFFF, 0, 1);
        send(50); chk("R9 first of two", alert, 0);
        smp_code = 12'd50;
        repeat (5) @(negedge clk);
        chk("R9 no strobe no advance", alert, 0);
        send(50); chk("R9 second strobe fires", alert, 1);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        chk("R9 disable clears alert", alert, 0);
        chk("R9 disable clears flag", cmp_lo, 0);
        chk("R9 sticky kept", stk_lo, 1);
        send(50); chk("R9 run restarted after disable", alert, 0);
        send(50); chk("R9 fires again", alert, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_low();
        t_high();
        t_extremes();
        t_hys_low();
        t_hys_high();
        t_count();
        t_break();
        t_sticky();
        t_valid_en();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule